// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

This block is the arithmetic and logic stage of a small 8/16-bit controller datapath. Each request presents a destination operand, a source operand, an operation code, a byte/word size select, a rotate/shift count, the current status byte and a flag-update mask. One clock later it returns the result, a write-enable for that result and the updated status byte. The status byte holds carry, auxiliary carry and zero. The operations are:

- Two-operand arithmetic and logic: add, add-with-carry, subtract, subtract-with-borrow, compare, and, or, xor and move.
- Rotates, with or without carry, and shifts (logical left, logical right, arithmetic right), applied a programmable number of times.

A two-state sequencer controls the output registers. `ST_IDLE` means no result is presented. `ST_DONE` means the output registers hold a freshly captured result and `out_valid` is high. The transitions are:

- IDLE_TO_DONE: taken on `in_valid`.
- DONE_TO_DONE: taken on a back-to-back `in_valid`.
- DONE_TO_IDLE: taken when `in_valid` is low.

While idle, the result, status and write-enable registers keep their last values.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset, `out_valid`, `result`, `status_out` and `wr_en` are all zero. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, the outputs hold their values.
- R2: Op codes: 0 = add, 1 = add-with-carry, 2 = subtract, 3 = subtract-with-borrow, 4 = compare, 5 = and, 6 = or, 7 = xor, 8 = move, 9 = rotate left, 10 = rotate left through carry, 11 = rotate right, 12 = rotate right through carry, 13 = shift left, 14 = logical shift right, 15 = arithmetic shift right. Add returns dst+src, and add-with-carry also adds the incoming carry, which is `status_in` bit 0.
- R3: Subtract returns dst−src, and subtract-with-borrow also subtracts the incoming carry. Compare computes dst−src for the flags only. For compare, `wr_en` is 0 and `result` returns dst. For every other op, `wr_en` is 1.
- R4: And, or and xor combine dst with src bitwise, and move returns src.
- R5: Status bit 0 (CY) is set when the bit just above the operand width (bit 8 for byte, bit 16 for word) differs between the raw result and the reference operand. The reference operand is src for move and dst for every other op.
- R6: Status bit 4 (AC) is set only when both of these hold:
  - bit 4 (byte) or bit 8 (word) differs between the raw result and the reference operand;
  - the result's low nibble (byte) or low byte (word) is numerically smaller than the reference operand's.
- R7: Status bit 6 (Z) is set when the result, truncated to the operand width, is zero.
- R8: For ops 0–8, only status bits whose `flag_mask` bit is 1 are recomputed. All other status bits pass through from `status_in` unchanged.
- R9: Rotate left moves the MSB into both the LSB and CY. Rotate left through carry moves the old CY into the LSB and the MSB into CY. The right-hand rotates mirror these, using the LSB.
- R10: Shift left and logical shift right insert zero, and arithmetic shift right keeps the sign bit. Each single-bit step puts the bit shifted out into CY, so after `cnt` steps CY holds the last bit shifted out. For ops 9–15, no status bit other than CY changes.
- R11: A rotate or shift with `cnt` = 0 returns the operand and `status_in` unchanged. The largest count, 15, performs 15 single-bit steps.
- R12: With `is_word` = 0, only the low 8 bits of both operands take part, and `result[15:8]` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code (R2 encoding) |
| is_word | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| dst | input | 16 | Destination operand (also the shift/rotate operand) |
| src | input | 16 | Source operand |
| cnt | input | 4 | Rotate/shift repeat count |
| status_in | input | 8 | Current status byte (CY bit 0, AC bit 4, Z bit 6) |
| flag_mask | input | 8 | Which status bits ops 0–8 may update |
| out_valid | output | 1 | Result registers are fresh |
| result | output | 16 | Registered result |
| wr_en | output | 1 | Result should be written back |
| status_out | output | 8 | Registered updated status byte |

## Verification
The assertions take for granted that all request inputs are known whenever `in_valid` is high. They also assume every 4-bit op code is meaningful, so no illegal code is ever excluded. The stimulus drives each request as a whole on the falling edge and holds it for exactly one rising edge. It covers every op code, counts of 0, 1, several and the maximum, and byte requests whose upper operand bits are non-zero. Mask-dependent properties are checked only for the two-operand ops, which the stimulus marks with full, partial and empty masks.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBC = 4'd3,
        OP_CMP  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_MOV  = 4'd8,
        OP_ROL  = 4'd9,
        OP_ROLC = 4'd10,
        OP_ROR  = 4'd11,
        OP_RORC = 4'd12,
        OP_SHL  = 4'd13,
        OP_SHR  = 4'd14,
        OP_SAR  = 4'd15
    } alu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } seq_state_e;

    localparam int FL_CY = 0;
    localparam int FL_AC = 4;
    localparam int FL_Z  = 6;
    localparam int ST_W  = 8;

    function automatic logic op_is_rotshift(input alu_op_e o);
        return (o >= OP_ROL);
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_core_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_op_e         op,
    input  logic            is_word,
    input  logic [DW-1:0]   dst,
    input  logic [DW-1:0]   src,
    input  logic            cin,
    output logic [DW-1:0]   res,
    output logic            cy,
    output logic            ac,
    output logic            zf
);
    localparam int HW = DW / 2;
    localparam int QW = HW / 2;

    logic [DW:0] d_ext;
    logic [DW:0] s_ext;
    logic [DW:0] c_ext;
    logic [DW:0] raw;
    logic [DW:0] ref_op;

    // operands narrowed to the active width, one guard bit on top
    always_comb begin
        if (is_word) begin
            d_ext = {1'b0, dst};
            s_ext = {1'b0, src};
        end else begin
            d_ext = {{(DW-HW+1){1'b0}}, dst[HW-1:0]};
            s_ext = {{(DW-HW+1){1'b0}}, src[HW-1:0]};
        end
        c_ext = {{DW{1'b0}}, cin};
    end

    always_comb begin
        unique case (op)
            OP_ADD:  raw = d_ext + s_ext;
            OP_ADDC: raw = d_ext + s_ext + c_ext;
            OP_SUB:  raw = d_ext - s_ext;
            OP_CMP:  raw = d_ext - s_ext;
            OP_SUBC: raw = d_ext - s_ext - c_ext;
            OP_AND:  raw = d_ext & s_ext;
            OP_OR:   raw = d_ext | s_ext;
            OP_XOR:  raw = d_ext ^ s_ext;
            default: raw = s_ext;
        endcase
        ref_op = (op == OP_MOV) ? s_ext : d_ext;
    end

    // flags derive from raw result versus the reference operand
    always_comb begin
        if (is_word) begin
            cy = raw[DW] ^ ref_op[DW];
            ac = (raw[HW] ^ ref_op[HW]) && (raw[HW-1:0] < ref_op[HW-1:0]);
            zf = (raw[DW-1:0] == '0);
        end else begin
            cy = raw[HW] ^ ref_op[HW];
            ac = (raw[QW] ^ ref_op[QW]) && (raw[QW-1:0] < ref_op[QW-1:0]);
            zf = (raw[HW-1:0] == '0);
        end
    end

    always_comb begin
        if (op == OP_CMP) begin
            res = d_ext[DW-1:0];
        end else if (is_word) begin
            res = raw[DW-1:0];
        end else begin
            res = {{(DW-HW){1'b0}}, raw[HW-1:0]};
        end
    end

endmodule

// File: rtl/alu_rotshift.sv
module alu_rotshift
    import alu_core_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CNT_W = 4
) (
    input  alu_op_e           op,
    input  logic              is_word,
    input  logic [DW-1:0]     val,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cin,
    output logic [DW-1:0]     res,
    output logic              cout
);
    localparam int HW   = DW / 2;
    localparam int MAXC = (1 << CNT_W) - 1;

    logic [DW-1:0] v;
    logic          c;

    // unrolled chain of single-bit steps, stage i active when i < cnt
    always_comb begin
        logic msb;
        logic lsb;
        logic ins;
        logic go_left;
        v = is_word ? val : {{(DW-HW){1'b0}}, val[HW-1:0]};
        c = cin;
        for (int i = 0; i < MAXC; i++) begin
            msb     = is_word ? v[DW-1] : v[HW-1];
            lsb     = v[0];
            ins     = 1'b0;
            go_left = 1'b0;
            case (op)
                OP_ROL:  begin ins = msb; go_left = 1'b1; end
                OP_ROLC: begin ins = c;   go_left = 1'b1; end
                OP_SHL:  begin ins = 1'b0; go_left = 1'b1; end
                OP_ROR:  ins = lsb;
                OP_RORC: ins = c;
                OP_SAR:  ins = msb;
                default: ins = 1'b0;
            endcase
            if (i < int'(cnt)) begin
                if (go_left) begin
                    v = {v[DW-2:0], ins};
                    c = msb;
                end else begin
                    v = v >> 1;
                    if (is_word) v[DW-1] = ins;
                    else         v[HW-1] = ins;
                    c = lsb;
                end
                if (!is_word) v[DW-1:HW] = '0;
            end
        end
        res  = v;
        cout = c;
    end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_core_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic              is_word,
    input  logic [DW-1:0]     dst,
    input  logic [DW-1:0]     src,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [7:0]        status_in,
    input  logic [7:0]        flag_mask,
    output logic              out_valid,
    output logic [DW-1:0]     result,
    output logic              wr_en,
    output logic [7:0]        status_out
);
    localparam int HW = DW / 2;

    alu_op_e       op_e;
    seq_state_e    state_q;
    seq_state_e    state_d;

    logic [DW-1:0] ar_res;
    logic          ar_cy;
    logic          ar_ac;
    logic          ar_z;
    logic [DW-1:0] sh_res;
    logic          sh_cy;

    logic [DW-1:0]   result_d;
    logic [ST_W-1:0] status_d;
    logic [ST_W-1:0] new_flags;
    logic            wr_d;

    assign op_e = alu_op_e'(op);

    alu_arith #(.DW(DW)) u_arith (
        .op      (op_e),
        .is_word (is_word),
        .dst     (dst),
        .src     (src),
        .cin     (status_in[FL_CY]),
        .res     (ar_res),
        .cy      (ar_cy),
        .ac      (ar_ac),
        .zf      (ar_z)
    );

    alu_rotshift #(.DW(DW), .CNT_W(CNT_W)) u_rotshift (
        .op      (op_e),
        .is_word (is_word),
        .val     (dst),
        .cnt     (cnt),
        .cin     (status_in[FL_CY]),
        .res     (sh_res),
        .cout    (sh_cy)
    );

    // next-value selection
    always_comb begin
        new_flags        = '0;
        new_flags[FL_CY] = ar_cy;
        new_flags[FL_AC] = ar_ac;
        new_flags[FL_Z]  = ar_z;
        if (op_is_rotshift(op_e)) begin
            result_d        = sh_res;
            status_d        = status_in;
            status_d[FL_CY] = sh_cy;
        end else begin
            result_d = ar_res;
            status_d = (status_in & ~flag_mask) | (new_flags & flag_mask);
        end
        wr_d = (op_e != OP_CMP);
    end

    // sequencer: next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;   // IDLE_TO_DONE
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;   // DONE_TO_DONE / DONE_TO_IDLE
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result     <= '0;
            status_out <= '0;
            wr_en      <= 1'b0;
        end else if (in_valid) begin
            result     <= result_d;
            status_out <= status_d;
            wr_en      <= wr_d;
        end
    end

    assign out_valid = (state_q == ST_DONE);

    // ---------------- assertions ----------------
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(result) && $stable(status_out));

    p_cmp_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == OP_CMP |=> !wr_en);

    p_keep_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op <= OP_MOV |=>
            ((status_out ^ $past(status_in)) & ~$past(flag_mask)) == 8'h00);

    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op >= OP_AND && op <= OP_MOV && flag_mask[FL_Z] |=>
            status_out[FL_Z] == (result == '0));

    p_rot_only_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op >= OP_ROL |=>
            ((status_out ^ $past(status_in)) & 8'hFE) == 8'h00);

    p_count_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op >= OP_ROL && cnt == '0 |=> status_out == $past(status_in));

    p_byte_upper_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !is_word |=> result[DW-1:HW] == '0);

endmodule

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  op;
        logic        wd;
        logic [15:0] dst;
        logic [15:0] src;
        logic [3:0]  cnt;
        logic [7:0]  st;
        logic [7:0]  msk;
        logic [15:0] eres;
        logic [7:0]  est;
        logic        ewr;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        // req op   wd  dst       src       cnt  st     msk    eres      est    ewr
        '{4'd2, 4'd0,  1'b0, 16'h003A, 16'h00C6, 4'd0, 8'h00, 8'h51, 16'h0000, 8'h51, 1'b1}, // R2 R5 R6 R7
        '{4'd2, 4'd1,  1'b1, 16'h12FF, 16'h0001, 4'd0, 8'h01, 8'h51, 16'h1301, 8'h10, 1'b1}, // R2 R6
        '{4'd5, 4'd0,  1'b1, 16'hFFFF, 16'h0001, 4'd0, 8'h00, 8'h51, 16'h0000, 8'h51, 1'b1}, // R5
        '{4'd3, 4'd2,  1'b0, 16'h0010, 16'h0001, 4'd0, 8'h00, 8'h51, 16'h000F, 8'h00, 1'b1}, // R3 R6
        '{4'd3, 4'd3,  1'b0, 16'h0000, 16'h0000, 4'd0, 8'h01, 8'h51, 16'h00FF, 8'h01, 1'b1}, // R3 R5
        '{4'd3, 4'd4,  1'b1, 16'h1234, 16'h1234, 4'd0, 8'h00, 8'h51, 16'h1234, 8'h40, 1'b0}, // R3 R7
        '{4'd4, 4'd5,  1'b0, 16'h00F0, 16'h003C, 4'd0, 8'h81, 8'h40, 16'h0030, 8'h81, 1'b1}, // R4 R8
        '{4'd7, 4'd6,  1'b1, 16'h0000, 16'h0000, 4'd0, 8'h00, 8'h40, 16'h0000, 8'h40, 1'b1}, // R4 R7
        '{4'd4, 4'd7,  1'b0, 16'h005A, 16'h005A, 4'd0, 8'h11, 8'h40, 16'h0000, 8'h51, 1'b1}, // R4
        '{4'd4, 4'd8,  1'b0, 16'h0077, 16'h0000, 4'd0, 8'h01, 8'h40, 16'h0000, 8'h41, 1'b1}, // R4
        '{4'd8, 4'd0,  1'b0, 16'h00FF, 16'h0001, 4'd0, 8'h24, 8'h00, 16'h0000, 8'h24, 1'b1}, // R8
        '{4'd9, 4'd9,  1'b0, 16'h0081, 16'h0000, 4'd1, 8'h00, 8'h51, 16'h0003, 8'h01, 1'b1}, // R9
        '{4'd9, 4'd10, 1'b0, 16'h0080, 16'h0000, 4'd2, 8'h00, 8'h51, 16'h0001, 8'h00, 1'b1}, // R9
        '{4'd9, 4'd11, 1'b1, 16'h0001, 16'h0000, 4'd1, 8'h00, 8'h00, 16'h8000, 8'h01, 1'b1}, // R9
        '{4'd9, 4'd12, 1'b0, 16'h0002, 16'h0000, 4'd1, 8'h01, 8'h00, 16'h0081, 8'h00, 1'b1}, // R9
        '{4'd10,4'd13, 1'b1, 16'hC001, 16'h0000, 4'd2, 8'h50, 8'h00, 16'h0004, 8'h51, 1'b1}, // R10
        '{4'd10,4'd14, 1'b0, 16'h0006, 16'h0000, 4'd3, 8'h00, 8'h00, 16'h0000, 8'h01, 1'b1}, // R10
        '{4'd10,4'd15, 1'b0, 16'h0084, 16'h0000, 4'd2, 8'h01, 8'h00, 16'h00E1, 8'h00, 1'b1}, // R10
        '{4'd11,4'd15, 1'b1, 16'h8001, 16'h0000, 4'd15,8'h00, 8'h00, 16'hFFFF, 8'h00, 1'b1}, // R11 max count
        '{4'd11,4'd10, 1'b0, 16'h005A, 16'h0000, 4'd0, 8'h01, 8'h00, 16'h005A, 8'h01, 1'b1}, // R11 zero count
        '{4'd11,4'd13, 1'b1, 16'hFFFF, 16'h0000, 4'd0, 8'h10, 8'h00, 16'hFFFF, 8'h10, 1'b1}, // R11 zero count
        '{4'd12,4'd0,  1'b0, 16'hAB12, 16'hCD01, 4'd0, 8'h00, 8'h51, 16'h0013, 8'h00, 1'b1}, // R12
        '{4'd12,4'd9,  1'b0, 16'hFF80, 16'h0000, 4'd1, 8'h00, 8'h00, 16'h0001, 8'h01, 1'b1}  // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic        is_word = 1'b0;
    logic [15:0] dst = '0;
    logic [15:0] src = '0;
    logic [3:0]  cnt = '0;
    logic [7:0]  status_in = '0;
    logic [7:0]  flag_mask = '0;
    logic        out_valid;
    logic [15:0] result;
    logic        wr_en;
    logic [7:0]  status_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    alu_flag_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op         (op),
        .is_word    (is_word),
        .dst        (dst),
        .src        (src),
        .cnt        (cnt),
        .status_in  (status_in),
        .flag_mask  (flag_mask),
        .out_valid  (out_valid),
        .result     (result),
        .wr_en      (wr_en),
        .status_out (status_out)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v, input int idx);
        @(negedge clk);
        in_valid  = 1'b1;
        op        = v.op;
        is_word   = v.wd;
        dst       = v.dst;
        src       = v.src;
        cnt       = v.cnt;
        status_in = v.st;
        flag_mask = v.msk;
        @(negedge clk);
        check($sformatf("R%0d vec%0d result", v.req, idx), result, v.eres);
        check($sformatf("R%0d vec%0d status", v.req, idx), {8'h00, status_out}, {8'h00, v.est});
        check($sformatf("R3 vec%0d wr_en", idx), {15'h0, wr_en}, {15'h0, v.ewr});
        check($sformatf("R1 vec%0d out_valid", idx), {15'h0, out_valid}, 16'h0001);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset out_valid", {15'h0, out_valid}, 16'h0000);
        check("R1 reset result", result, 16'h0000);
        check("R1 reset status", {8'h00, status_out}, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) apply(VECS[i], i);

        // R1 idle: outputs hold, out_valid drops
        @(negedge clk);
        check("R1 idle out_valid", {15'h0, out_valid}, 16'h0000);
        dst = 16'h1111; status_in = 8'hFF; op = 4'd0;
        @(negedge clk);
        check("R1 idle result hold", result, 16'h0001);
        check("R1 idle status hold", {8'h00, status_out}, 16'h0001);

        // R1 back-to-back requests keep out_valid high
        in_valid = 1'b1; op = 4'd8; is_word = 1'b1; src = 16'hBEEF;
        status_in = 8'h00; flag_mask = 8'h00;
        @(negedge clk);
        src = 16'h0042;
        @(negedge clk);
        check("R1 back-to-back out_valid", {15'h0, out_valid}, 16'h0001);
        check("R4 back-to-back move", result, 16'h0042);
        in_valid = 1'b0;

        // R1 reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset out_valid", {15'h0, out_valid}, 16'h0000);
        check("R1 mid reset result", result, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule